// File: doc/BRIEF.md
# Edge-Timing Carrier Detector

This block decides whether a sliced symbol stream, delivered one bit per sample strobe, carries real data. A signed phase accumulator free-runs at the baud rate: it gains a programmable step on every strobe and wraps, passing through zero once per symbol period. When a symbol edge arrives near that zero crossing, a score rises by a large increment. When an edge arrives elsewhere, the score falls by a small decrement, and it never drops below zero. A ceiling keeps the score from piling up, so the flag can drop again soon after the signal goes away. The carrier-detect flag is raised while the score is above a threshold.

On every edge the accumulator is scaled by a phase-adjust factor, which pulls its phase toward the edge. A factor of zero snaps the phase to zero on each edge. All tuning values are static inputs. The caller changes them only while reset is held.

The flag is a two-state machine. In state `CD_ABSENT` the flag is low. Transition ACQUIRE moves to `CD_PRESENT` when an updated score exceeds the threshold. Transition RELEASE returns to `CD_ABSENT` when an updated score is at or below it. The machine changes state only on a strobe.

Top module: `carrier_detect_pll`

## Requirements
- R1: On a strobe, the accumulator (width ACC_W, signed) advances by `phase_step` modulo 2^ACC_W. Without a strobe, the accumulator, score, flag and stored symbol all hold.
- R2: A symbol edge is seen on a strobe whose `symbol_in` differs from the bit stored at the previous strobe, which is 0 after reset. The stored bit is updated on every strobe. A level that is held produces no edge, whatever `symbol_in` does between strobes.
- R3: An edge is in time when the absolute value of the advanced accumulator is strictly less than `phase_step`. A value equal to one step is out of time.
- R4: An in-time edge adds `score_inc` to the score.
- R5: An out-of-time edge subtracts `score_dec` only when the score is at least `score_dec`. Otherwise the score is unchanged.
- R6: After every strobe update, a score above `score_max` is replaced by `score_max`.
- R7: `carrier_detect` is 1 exactly when the score is strictly greater than `score_thr`. It updates in the same cycle as the score, one clock after the strobe.
- R8: On an edge, the accumulator becomes the advanced value times `phase_adjust`/256, truncated toward zero. With `phase_adjust` = 0 it becomes 0.
- R9: A synchronous reset clears the accumulator, score, stored symbol and flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_strobe | input | 1 | One pulse per symbol sample |
| symbol_in | input | 1 | Sliced symbol bit |
| phase_step | input | ACC_W | Accumulator increment per sample (2^ACC_W / samples per symbol) |
| score_inc | input | SCORE_W | Score gain for an in-time edge |
| score_dec | input | SCORE_W | Score loss for an out-of-time edge |
| score_max | input | SCORE_W | Score ceiling |
| score_thr | input | SCORE_W | Detect threshold |
| phase_adjust | input | ADJ_W | Unsigned phase scale factor, value/256 |
| carrier_detect | output | 1 | Carrier present flag |
| score | output | SCORE_W | Current score |

## Verification
The bench uses the default widths with `phase_step` = 2^29, which gives eight samples per symbol. With this step, an edge eight strobes after the previous phase reset lands exactly on the wrap to zero. Edges seven or nine strobes after it land at exactly one step, which probes the strict window edge. The low-rate tuning set (ceiling 100, threshold 30, +7/-1) reaches the ceiling in 15 edges, and the high-rate set (200, 80, +6/-3) exercises the zero floor. A phase-adjust factor of 128 makes a seven-strobe edge fall in time where a factor of zero makes it fall out of time.

// File: rtl/cdet_pkg.sv
package cdet_pkg;

    typedef enum logic {
        CD_ABSENT  = 1'b0,
        CD_PRESENT = 1'b1
    } cd_state_t;

endpackage

// File: rtl/cdet_phase.sv
module cdet_phase #(
    parameter int ACC_W = 32,
    parameter int ADJ_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic             edge_seen,
    input  logic [ACC_W-1:0] step,
    input  logic [ADJ_W-1:0] adj,
    output logic             in_time
);
    localparam int PROD_W = ACC_W + ADJ_W;

    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  acc_adv;
    logic              adv_neg;
    logic [ACC_W-1:0]  adv_mag;
    logic [PROD_W-1:0] prod;
    logic [ACC_W-1:0]  scaled_mag;
    logic [ACC_W-1:0]  acc_pulled;

    // Advance and window test
    always_comb begin
        acc_adv = acc_q + step;
        adv_neg = acc_adv[ACC_W-1];
        adv_mag = adv_neg ? (~acc_adv + 1'b1) : acc_adv;
        in_time = adv_mag < step;
    end

    // Scale magnitude so truncation goes toward zero, then restore sign
    always_comb begin
        prod       = PROD_W'(adv_mag) * PROD_W'(adj);
        scaled_mag = prod[PROD_W-1:ADJ_W];
        acc_pulled = adv_neg ? (~scaled_mag + 1'b1) : scaled_mag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (strobe) begin
            acc_q <= edge_seen ? acc_pulled : acc_adv;
        end
    end

    assert_phase_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(acc_q));

    assert_phase_advance_R1: assert property (@(posedge clk) disable iff (rst)
        (strobe && !edge_seen) |=> (acc_q == $past(acc_q) + $past(step)));

    assert_phase_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (strobe && edge_seen && adj == '0) |=> (acc_q == '0));

endmodule

// File: rtl/cdet_score.sv
module cdet_score
    import cdet_pkg::*;
#(
    parameter int SCORE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               strobe,
    input  logic               edge_seen,
    input  logic               in_time,
    input  logic [SCORE_W-1:0] inc,
    input  logic [SCORE_W-1:0] dec,
    input  logic [SCORE_W-1:0] ceil_val,
    input  logic [SCORE_W-1:0] thr,
    output logic [SCORE_W-1:0] score,
    output logic               cd
);
    localparam int WIDE_W = SCORE_W + 1;

    logic [SCORE_W-1:0] score_q;
    logic [WIDE_W-1:0]  raw_next;
    logic [SCORE_W-1:0] score_next;
    cd_state_t          state_q;
    cd_state_t          state_next;

    // Score arithmetic
    always_comb begin
        raw_next = WIDE_W'(score_q);
        if (edge_seen && in_time) begin
            raw_next = WIDE_W'(score_q) + WIDE_W'(inc);
        end else if (edge_seen && (score_q >= dec)) begin
            raw_next = WIDE_W'(score_q) - WIDE_W'(dec);
        end
        score_next = (raw_next > WIDE_W'(ceil_val)) ? ceil_val : raw_next[SCORE_W-1:0];
    end

    // Next state: ACQUIRE / RELEASE
    always_comb begin
        state_next = state_q;
        if (strobe) begin
            unique case (state_q)
                CD_ABSENT:  if (score_next > thr)   state_next = CD_PRESENT;
                CD_PRESENT: if (!(score_next > thr)) state_next = CD_ABSENT;
                default:    state_next = CD_ABSENT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CD_ABSENT;
        end else begin
            state_q <= state_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            score_q <= '0;
        end else if (strobe) begin
            score_q <= score_next;
        end
    end

    // Outputs
    always_comb begin
        cd    = (state_q == CD_PRESENT);
        score = score_q;
    end

    assert_ceiling_R6: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (score_q <= $past(ceil_val)));

    assert_no_rise_when_late_R5: assert property (@(posedge clk) disable iff (rst)
        (strobe && edge_seen && !in_time) |=> (score_q <= $past(score_q)));

    assert_gain_R4: assert property (@(posedge clk) disable iff (rst)
        (strobe && edge_seen && in_time &&
         (WIDE_W'(score_q) + WIDE_W'(inc) <= WIDE_W'(ceil_val)))
        |=> (WIDE_W'(score_q) == WIDE_W'($past(score_q)) + WIDE_W'($past(inc))));

    assert_flag_matches_R7: assert property (@(posedge clk) disable iff (rst)
        cd == (score_q > thr));

    assert_score_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(score_q));

endmodule

// File: rtl/carrier_detect_pll.sv
module carrier_detect_pll #(
    parameter int ACC_W   = 32,
    parameter int SCORE_W = 8,
    parameter int ADJ_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sample_strobe,
    input  logic               symbol_in,
    input  logic [ACC_W-1:0]   phase_step,
    input  logic [SCORE_W-1:0] score_inc,
    input  logic [SCORE_W-1:0] score_dec,
    input  logic [SCORE_W-1:0] score_max,
    input  logic [SCORE_W-1:0] score_thr,
    input  logic [ADJ_W-1:0]   phase_adjust,
    output logic               carrier_detect,
    output logic [SCORE_W-1:0] score
);
    logic last_sym_q;
    logic edge_seen;
    logic in_time;

    assign edge_seen = (symbol_in != last_sym_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_sym_q <= 1'b0;
        end else if (sample_strobe) begin
            last_sym_q <= symbol_in;
        end
    end

    cdet_phase #(
        .ACC_W (ACC_W),
        .ADJ_W (ADJ_W)
    ) u_phase (
        .clk       (clk),
        .rst       (rst),
        .strobe    (sample_strobe),
        .edge_seen (edge_seen),
        .step      (phase_step),
        .adj       (phase_adjust),
        .in_time   (in_time)
    );

    cdet_score #(
        .SCORE_W (SCORE_W)
    ) u_score (
        .clk       (clk),
        .rst       (rst),
        .strobe    (sample_strobe),
        .edge_seen (edge_seen),
        .in_time   (in_time),
        .inc       (score_inc),
        .dec       (score_dec),
        .ceil_val  (score_max),
        .thr       (score_thr),
        .score     (score),
        .cd        (carrier_detect)
    );

    assert_held_level_R2: assert property (@(posedge clk) disable iff (rst)
        (sample_strobe && !edge_seen) |=> $stable(score));

endmodule

// File: tb/carrier_detect_pll_bench.sv
`timescale 1ns/100ps
module carrier_detect_pll_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stb = 1'b0;
    logic        sym = 1'b0;
    logic [31:0] step = 32'h2000_0000;
    logic [7:0]  inc, dec, mx, thr, adj;
    logic        cd;
    logic [7:0]  score;

    int checks = 0;
    int failures = 0;
    logic cur = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    carrier_detect_pll u_carrier_detect_pll (
        .clk(clk), .rst(rst), .sample_strobe(stb), .symbol_in(sym),
        .phase_step(step), .score_inc(inc), .score_dec(dec),
        .score_max(mx), .score_thr(thr), .phase_adjust(adj),
        .carrier_detect(cd), .score(score)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic do_reset(input int m, input int t, input int i, input int d, input int a);
        @(negedge clk);
        rst = 1'b1; stb = 1'b0; sym = 1'b0; cur = 1'b0;
        mx = 8'(m); thr = 8'(t); inc = 8'(i); dec = 8'(d); adj = 8'(a);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse(input logic b);
        @(negedge clk);
        sym = b; stb = 1'b1;
        @(negedge clk);
        stb = 1'b0;
    endtask

    // Each edge comes `period` strobes after the previous one
    task automatic edges(input int period, input int count);
        for (int n = 0; n < count; n++) begin
            for (int k = 0; k < period - 1; k++) pulse(cur);
            cur = ~cur;
            pulse(cur);
        end
    endtask

    task automatic t_reset();
        do_reset(100, 30, 7, 1, 0);
        check("R9 score after reset", score, 0);
        check("R9 flag after reset", cd, 0);
        edges(8, 6);
        do_reset(100, 30, 7, 1, 0);
        check("R9 score cleared", score, 0);
        check("R9 flag cleared", cd, 0);
    endtask

    task automatic t_lock();
        do_reset(100, 30, 7, 1, 0);
        edges(8, 4);
        check("R4 R1 four in-time edges", score, 28);
        check("R7 below threshold", cd, 0);
        edges(8, 1);
        check("R4 fifth edge", score, 35);
        check("R7 above threshold", cd, 1);
        edges(8, 15);
        check("R6 ceiling", score, 100);
    endtask

    task automatic t_window();
        // continues from t_lock at score 100
        edges(7, 1);
        check("R3 one step early is out of time", score, 99);
        edges(9, 1);
        check("R3 one step late is out of time", score, 98);
        edges(3, 10);
        check("R5 repeated out-of-time edges", score, 88);
        check("R7 flag stays", cd, 1);
    endtask

    task automatic t_floor();
        do_reset(200, 80, 6, 3, 0);
        edges(3, 5);
        check("R5 floor at zero", score, 0);
        edges(8, 1);
        check("R4 high-rate gain", score, 6);
        edges(3, 1);
        check("R5 subtract when allowed", score, 3);
        edges(3, 1);
        check("R5 subtract to zero", score, 0);
        edges(5, 1);
        check("R5 no subtract below dec", score, 0);
    endtask

    task automatic t_hold();
        do_reset(100, 30, 7, 1, 0);
        edges(8, 2);
        check("R4 setup", score, 14);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); sym = ~sym;
        end
        @(negedge clk); sym = cur;
        repeat (2) @(negedge clk);
        check("R1 no strobe no change", score, 14);
        for (int k = 0; k < 20; k++) pulse(cur);
        check("R2 held level no edge", score, 14);
        check("R2 flag unchanged", cd, 0);
    endtask

    task automatic t_thresh();
        do_reset(100, 28, 7, 1, 0);
        edges(8, 4);
        check("R7 equal to threshold", cd, 0);
        edges(8, 1);
        check("R7 above threshold", cd, 1);
        edges(5, 7);
        check("R7 score back to threshold", score, 28);
        check("R7 release", cd, 0);
    endtask

    task automatic t_adjust();
        do_reset(100, 30, 7, 1, 128);
        edges(9, 1);
        check("R8 first edge out of time", score, 0);
        edges(7, 1);
        check("R8 half pull makes edge in time", score, 7);
        do_reset(100, 30, 7, 1, 0);
        edges(9, 1);
        edges(7, 1);
        check("R8 zero factor resets phase", score, 0);
    endtask

    initial begin
        t_reset();
        t_lock();
        t_window();
        t_floor();
        t_hold();
        t_thresh();
        t_adjust();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule